// File: doc/BRIEF.md
# Link equalization phase sequencer

This block controls one lane of a serial link while the transmitter settings are tuned after a change to a data rate of 8 GT/s or more. It moves through four numbered phases and reports the current phase as a 2-bit code, which the framing logic places in every outgoing training set. A role input selects downstream-port or upstream-port behaviour. The two roles enter at different phases. In the two tuning phases the roles swap: one side asks for new transmitter settings, and the other side applies them.

The block does not parse training sets, measure error rates or drive analog circuits. Its inputs are the decoded fields of each received training set, plus two quality flags and a legality flag from an external link evaluator. Its outputs are the phase code to transmit, a reject flag for the last request, the transmitter setting currently in force (either a preset or a pre/cursor/post coefficient triple), the partner's captured full-swing and low-frequency values, and busy, done and fail status. A start pulse arms the sequence, and a programmable per-phase cycle limit stops a partner that never answers.

Top module: `eqseq_top`

## Requirements
- R1: After synchronous reset, txEc is 00, busy, done, fail and txReject are 0, and every applied-setting output is 0.
- R2: A start pulse while rateOk is 0 leaves the block idle, with busy 0, txEc 00, and done and fail both 0.
- R3: A start pulse while rateOk is 1 sets busy. With roleDown=1 the block enters phase 1, and with roleDown=0 it enters phase 0. While busy, txEc carries the phase number (00, 01, 10 or 11). When not busy, txEc is 00.
- R4: In phase 0, the block moves to phase 1 only on the second of two consecutive received sets (rxValid) with rxEc=01, and only if qualLow is 1 on that second set. A received set with any other code restarts the count.
- R5: In phase 1, every received set with rxEc=01 loads partnerFs and partnerLf from rxFs and rxLf.
- R6: Phase 1 ends on two consecutive sets with rxEc=01 while qualLow is 1. If qualHigh is also 1, the block sets done, goes idle with txEc 00 and skips phases 2 and 3. Otherwise it enters phase 2.
- R7: On the tuned side (roleDown=1 in phase 2, roleDown=0 in phase 3), a received set whose rxEc equals the current phase code is a request. If reqLegal is 1, the request is applied at the next edge. With rxPresetReq=1, appIsPreset becomes 1, appPreset takes rxPreset, and the coefficients stay as they were. With rxPresetReq=0, appIsPreset becomes 0 and appPre, appCur and appPost take the received triple.
- R8: A request with reqLegal=0 is not applied. It sets txReject and leaves the phase unchanged. The next applied request clears txReject.
- R9: On the tuned side, phase 2 moves to phase 3 on two consecutive sets with rxEc=11. Phase 3 finishes (done, idle) on two consecutive sets with rxEc=00.
- R10: On the tuning side (roleDown=0 in phase 2, roleDown=1 in phase 3), the phase ends when qualHigh is 1. Phase 2 moves to phase 3, and phase 3 sets done and goes idle.
- R11: If the block spends toutLimit+1 consecutive cycles in one phase without advancing, it sets fail, clears busy and returns txEc to 00.
- R12: The applied-setting outputs change only on an applied request on the tuned side. Requests received in any other phase or role, or while idle, have no effect on them.
- R13: A start pulse re-arms the sequencer from any state. It clears done and fail and enters the role's entry phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Arms or re-arms the sequence |
| rateOk | input | 1 | Target or current rate is at least 8 GT/s |
| roleDown | input | 1 | 1 selects downstream-port role, 0 selects upstream-port role |
| toutLimit | input | TMR_W | Per-phase cycle limit |
| rxValid | input | 1 | A decoded training set is present this cycle |
| rxEc | input | 2 | Received phase code |
| rxPresetReq | input | 1 | Received request is a preset |
| rxPreset | input | PW | Received preset index |
| rxPre | input | CW | Received pre-cursor coefficient |
| rxCur | input | CW | Received cursor coefficient |
| rxPost | input | CW | Received post-cursor coefficient |
| rxFs | input | CW | Partner full-swing value |
| rxLf | input | CW | Partner low-frequency value |
| reqLegal | input | 1 | Evaluator accepts the present request |
| qualLow | input | 1 | Error rate better than 1e-4 |
| qualHigh | input | 1 | Error rate better than 1e-12 |
| txEc | output | 2 | Phase code to transmit |
| txReject | output | 1 | Last request was rejected |
| appIsPreset | output | 1 | Applied setting is a preset |
| appPreset | output | PW | Applied preset index |
| appPre | output | CW | Applied pre-cursor |
| appCur | output | CW | Applied cursor |
| appPost | output | CW | Applied post-cursor |
| partnerFs | output | CW | Captured partner full-swing |
| partnerLf | output | CW | Captured partner low-frequency |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished successfully |
| fail | output | 1 | A phase timed out |

## Verification
The bench sends a pair of matching sets split by a set with another code. A design that counted matching sets without requiring them to be consecutive would leave the phase one set too early. It also sends requests to the tuning side and after completion. A block that applied settings regardless of role or phase would corrupt the applied coefficients. An illegal request between two legal ones shows whether a rejected setting leaks into the registers or whether the reject flag fails to clear. The early exit from phase 1, and a timeout checked one cycle before and at the expiry edge, catch a design that always runs all four phases or whose cycle limit is off by one.

// File: rtl/eqseq_pkg.sv
package eqseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PH0,
    ST_PH1,
    ST_PH2,
    ST_PH3
  } eqState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic       phaseClr;  // entering a new phase (or re-arm)
    logic       inPhase;   // sequence running
    logic [1:0] expEc;     // code that counts toward the pair
    logic [1:0] reqEc;     // code carried by requests in this phase
    logic       capFsLf;   // phase 1 capture window
    logic       tuneEn;    // this side's transmitter is being tuned
  } eqStrobe_t;

  // Status from the datapath back to the FSM
  typedef struct packed {
    logic pairHit;   // second consecutive matching set this cycle
    logic expired;   // per-phase cycle limit reached
  } eqStatus_t;

endpackage

// File: rtl/eqseq_ctrl.sv
module eqseq_ctrl
  import eqseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       rateOk,
  input  logic       roleDown,
  input  logic       qualLow,
  input  logic       qualHigh,
  input  eqStatus_t  sts,
  output eqStrobe_t  str,
  output logic [1:0] txEc,
  output logic       busy,
  output logic       done,
  output logic       fail
);

  eqState_t state, nxtState;
  logic     nxtDone, nxtFail;

  // Next-state logic: re-arm > advance > timeout
  always_comb begin
    nxtState = state;
    nxtDone  = done;
    nxtFail  = fail;
    unique case (state)
      ST_PH0: begin
        if (sts.pairHit && qualLow) nxtState = ST_PH1;
      end
      ST_PH1: begin
        if (sts.pairHit && qualLow) begin
          if (qualHigh) begin
            nxtState = ST_IDLE;
            nxtDone  = 1'b1;
          end else begin
            nxtState = ST_PH2;
          end
        end
      end
      ST_PH2: begin
        if (roleDown ? sts.pairHit : qualHigh) nxtState = ST_PH3;
      end
      ST_PH3: begin
        if (roleDown ? qualHigh : sts.pairHit) begin
          nxtState = ST_IDLE;
          nxtDone  = 1'b1;
        end
      end
      default: ;
    endcase
    if ((state != ST_IDLE) && (nxtState == state) && sts.expired) begin
      nxtState = ST_IDLE;
      nxtFail  = 1'b1;
    end
    if (start) begin
      nxtDone  = 1'b0;
      nxtFail  = 1'b0;
      nxtState = rateOk ? (roleDown ? ST_PH1 : ST_PH0) : ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      state <= nxtState;
      done  <= nxtDone;
      fail  <= nxtFail;
    end
  end

  // Strobe decode
  always_comb begin
    str          = '0;
    str.phaseClr = start || (nxtState != state);
    str.inPhase  = (state != ST_IDLE);
    str.capFsLf  = (state == ST_PH1);
    str.tuneEn   = ((state == ST_PH2) && roleDown) || ((state == ST_PH3) && !roleDown);
    unique case (state)
      ST_PH0:  begin str.expEc = 2'b01; str.reqEc = 2'b00; end
      ST_PH1:  begin str.expEc = 2'b01; str.reqEc = 2'b01; end
      ST_PH2:  begin str.expEc = 2'b11; str.reqEc = 2'b10; end
      ST_PH3:  begin str.expEc = 2'b00; str.reqEc = 2'b11; end
      default: begin str.expEc = 2'b00; str.reqEc = 2'b00; end
    endcase
  end

  always_comb begin
    unique case (state)
      ST_PH1:  txEc = 2'b01;
      ST_PH2:  txEc = 2'b10;
      ST_PH3:  txEc = 2'b11;
      default: txEc = 2'b00;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R2: no rate, no sequence
  a_r2_no_rate: assert property (@(posedge clk) disable iff (rst)
    (start && !rateOk) |=> (!busy && !done && !fail));

  // R3: role-dependent entry phase
  a_r3_entry: assert property (@(posedge clk) disable iff (rst)
    (start && rateOk) |=> (busy && (txEc == ($past(roleDown) ? 2'b01 : 2'b00))));

  // R6/R10: completion only out of phase 1 or phase 3
  a_r10_done_origin: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(state) == ST_PH1 || $past(state) == ST_PH3));

  // R11: failure only after the datapath flags expiry
  a_r11_fail_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> $past(sts.expired));

  // R4: phase 0 never advances without the low-quality threshold met
  a_r4_gate: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PH0 && !qualLow && !start) |=> (state != ST_PH1));

  a_r13_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));

endmodule

// File: rtl/eqseq_dp.sv
module eqseq_dp
  import eqseq_pkg::*;
#(
  parameter int CW    = 6,
  parameter int PW    = 4,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  eqStrobe_t        str,
  input  logic             rxValid,
  input  logic [1:0]       rxEc,
  input  logic             rxPresetReq,
  input  logic [PW-1:0]    rxPreset,
  input  logic [CW-1:0]    rxPre,
  input  logic [CW-1:0]    rxCur,
  input  logic [CW-1:0]    rxPost,
  input  logic [CW-1:0]    rxFs,
  input  logic [CW-1:0]    rxLf,
  input  logic             reqLegal,
  input  logic [TMR_W-1:0] toutLimit,
  output eqStatus_t        sts,
  output logic             txReject,
  output logic             appIsPreset,
  output logic [PW-1:0]    appPreset,
  output logic [CW-1:0]    appPre,
  output logic [CW-1:0]    appCur,
  output logic [CW-1:0]    appPost,
  output logic [CW-1:0]    partnerFs,
  output logic [CW-1:0]    partnerLf
);

  localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};

  logic [1:0]       pairCnt;
  logic [TMR_W-1:0] timer;
  logic             setMatch, reqHit, applyNow, rejectNow;

  assign setMatch  = rxValid && (rxEc == str.expEc);
  assign reqHit    = str.tuneEn && rxValid && (rxEc == str.reqEc);
  assign applyNow  = reqHit && reqLegal;
  assign rejectNow = reqHit && !reqLegal;

  assign sts.pairHit = setMatch && (pairCnt != 2'd0);
  assign sts.expired = str.inPhase && (timer == toutLimit);

  // Consecutive-set counter, saturating at two
  always_ff @(posedge clk) begin
    if (rst || str.phaseClr) begin
      pairCnt <= 2'd0;
    end else if (rxValid) begin
      if (!setMatch)             pairCnt <= 2'd0;
      else if (pairCnt != 2'd2)  pairCnt <= pairCnt + 2'd1;
    end
  end

  // Per-phase cycle timer
  always_ff @(posedge clk) begin
    if (rst || str.phaseClr)                 timer <= '0;
    else if (str.inPhase && timer != TMR_MAX) timer <= timer + 1'b1;
  end

  // Applied transmitter setting
  always_ff @(posedge clk) begin
    if (rst) begin
      appIsPreset <= 1'b0;
      appPreset   <= '0;
      appPre      <= '0;
      appCur      <= '0;
      appPost     <= '0;
    end else if (applyNow) begin
      if (rxPresetReq) begin
        appIsPreset <= 1'b1;
        appPreset   <= rxPreset;
      end else begin
        appIsPreset <= 1'b0;
        appPre      <= rxPre;
        appCur      <= rxCur;
        appPost     <= rxPost;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || str.phaseClr) txReject <= 1'b0;
    else if (applyNow)       txReject <= 1'b0;
    else if (rejectNow)      txReject <= 1'b1;
  end

  // Partner full-swing / low-frequency capture
  always_ff @(posedge clk) begin
    if (rst) begin
      partnerFs <= '0;
      partnerLf <= '0;
    end else if (str.capFsLf && rxValid && rxEc == 2'b01) begin
      partnerFs <= rxFs;
      partnerLf <= rxLf;
    end
  end

  // R12: setting held whenever this side is not being tuned
  a_r12_app_hold: assert property (@(posedge clk) disable iff (rst)
    !str.tuneEn |=> $stable({appIsPreset, appPreset, appPre, appCur, appPost}));

  // R8: an illegal request leaves the setting and raises reject
  a_r8_reject: assert property (@(posedge clk) disable iff (rst)
    (str.tuneEn && rxValid && rxEc == str.reqEc && !reqLegal)
      |=> (txReject && $stable({appIsPreset, appPreset, appPre, appCur, appPost})));

  // R7: a legal coefficient request lands in the registers
  a_r7_coeff_apply: assert property (@(posedge clk) disable iff (rst)
    (str.tuneEn && rxValid && rxEc == str.reqEc && reqLegal && !rxPresetReq)
      |=> (!appIsPreset && appPre == $past(rxPre) && appCur == $past(rxCur)
           && appPost == $past(rxPost)));

  // R7: a legal preset request keeps the coefficients
  a_r7_preset_apply: assert property (@(posedge clk) disable iff (rst)
    (str.tuneEn && rxValid && rxEc == str.reqEc && reqLegal && rxPresetReq)
      |=> (appIsPreset && appPreset == $past(rxPreset) && $stable(appPre)));

endmodule

// File: rtl/eqseq_top.sv
module eqseq_top
  import eqseq_pkg::*;
#(
  parameter int CW    = 6,
  parameter int PW    = 4,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rateOk,
  input  logic             roleDown,
  input  logic [TMR_W-1:0] toutLimit,
  input  logic             rxValid,
  input  logic [1:0]       rxEc,
  input  logic             rxPresetReq,
  input  logic [PW-1:0]    rxPreset,
  input  logic [CW-1:0]    rxPre,
  input  logic [CW-1:0]    rxCur,
  input  logic [CW-1:0]    rxPost,
  input  logic [CW-1:0]    rxFs,
  input  logic [CW-1:0]    rxLf,
  input  logic             reqLegal,
  input  logic             qualLow,
  input  logic             qualHigh,
  output logic [1:0]       txEc,
  output logic             txReject,
  output logic             appIsPreset,
  output logic [PW-1:0]    appPreset,
  output logic [CW-1:0]    appPre,
  output logic [CW-1:0]    appCur,
  output logic [CW-1:0]    appPost,
  output logic [CW-1:0]    partnerFs,
  output logic [CW-1:0]    partnerLf,
  output logic             busy,
  output logic             done,
  output logic             fail
);

  eqStrobe_t str;
  eqStatus_t sts;

  eqseq_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rateOk   (rateOk),
    .roleDown (roleDown),
    .qualLow  (qualLow),
    .qualHigh (qualHigh),
    .sts      (sts),
    .str      (str),
    .txEc     (txEc),
    .busy     (busy),
    .done     (done),
    .fail     (fail)
  );

  eqseq_dp #(.CW(CW), .PW(PW), .TMR_W(TMR_W)) uDp (
    .clk         (clk),
    .rst         (rst),
    .str         (str),
    .rxValid     (rxValid),
    .rxEc        (rxEc),
    .rxPresetReq (rxPresetReq),
    .rxPreset    (rxPreset),
    .rxPre       (rxPre),
    .rxCur       (rxCur),
    .rxPost      (rxPost),
    .rxFs        (rxFs),
    .rxLf        (rxLf),
    .reqLegal    (reqLegal),
    .toutLimit   (toutLimit),
    .sts         (sts),
    .txReject    (txReject),
    .appIsPreset (appIsPreset),
    .appPreset   (appPreset),
    .appPre      (appPre),
    .appCur      (appCur),
    .appPost     (appPost),
    .partnerFs   (partnerFs),
    .partnerLf   (partnerLf)
  );

endmodule

// File: tb/eqseq_top_test.sv
module eqseq_top_test;

  localparam int CW = 6, PW = 4, TMR_W = 16;

  localparam int F_EC = 0, F_BUSY = 1, F_DONE = 2, F_FAIL = 3, F_ISP = 4,
                 F_PSET = 5, F_PRE = 6, F_CUR = 7, F_POST = 8, F_FS = 9,
                 F_LF = 10, F_REJ = 11;

  logic clk = 1'b0;
  logic rst = 1'b1, start = 1'b0, rateOk = 1'b0, roleDown = 1'b0;
  logic [TMR_W-1:0] toutLimit = 16'd40;
  logic rxValid = 1'b0, rxPresetReq = 1'b0, reqLegal = 1'b0;
  logic [1:0] rxEc = 2'b00;
  logic [PW-1:0] rxPreset = '0;
  logic [CW-1:0] rxPre = '0, rxCur = '0, rxPost = '0, rxFs = '0, rxLf = '0;
  logic qualLow = 1'b0, qualHigh = 1'b0;
  logic [1:0] txEc;
  logic txReject, appIsPreset, busy, done, fail;
  logic [PW-1:0] appPreset;
  logic [CW-1:0] appPre, appCur, appPost, partnerFs, partnerLf;

  int nApplied = 0, nBad = 0;
  bit finished = 0;
  string qReq[$];
  int    qSel[$];
  int    qExp[$];

  always #5 clk = ~clk;

  eqseq_top #(.CW(CW), .PW(PW), .TMR_W(TMR_W)) uut (
    .clk(clk), .rst(rst), .start(start), .rateOk(rateOk), .roleDown(roleDown),
    .toutLimit(toutLimit), .rxValid(rxValid), .rxEc(rxEc),
    .rxPresetReq(rxPresetReq), .rxPreset(rxPreset), .rxPre(rxPre),
    .rxCur(rxCur), .rxPost(rxPost), .rxFs(rxFs), .rxLf(rxLf),
    .reqLegal(reqLegal), .qualLow(qualLow), .qualHigh(qualHigh),
    .txEc(txEc), .txReject(txReject), .appIsPreset(appIsPreset),
    .appPreset(appPreset), .appPre(appPre), .appCur(appCur), .appPost(appPost),
    .partnerFs(partnerFs), .partnerLf(partnerLf), .busy(busy), .done(done),
    .fail(fail)
  );

  function automatic int observe(input int sel);
    case (sel)
      F_EC:    return int'(txEc);
      F_BUSY:  return int'(busy);
      F_DONE:  return int'(done);
      F_FAIL:  return int'(fail);
      F_ISP:   return int'(appIsPreset);
      F_PSET:  return int'(appPreset);
      F_PRE:   return int'(appPre);
      F_CUR:   return int'(appCur);
      F_POST:  return int'(appPost);
      F_FS:    return int'(partnerFs);
      F_LF:    return int'(partnerLf);
      default: return int'(txReject);
    endcase
  endfunction

  // Monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (qSel.size() > 0) begin
      string r;
      int s, e, a;
      r = qReq.pop_front();
      s = qSel.pop_front();
      e = qExp.pop_front();
      a = observe(s);
      nApplied++;
      if (a !== e) begin
        nBad++;
        $display("FAIL %s field %0d: actual %0d expected %0d at %0t", r, s, a, e, $time);
      end
    end
  end

  task automatic want(input string r, input int sel, input int v);
    qReq.push_back(r);
    qSel.push_back(sel);
    qExp.push_back(v);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic sendTs(input logic [1:0] ec, input logic pf, input int pidx,
                        input int pr, input int cu, input int po,
                        input int fs, input int lf, input logic legal);
    rxValid = 1'b1; rxEc = ec; rxPresetReq = pf; rxPreset = pidx[PW-1:0];
    rxPre = pr[CW-1:0]; rxCur = cu[CW-1:0]; rxPost = po[CW-1:0];
    rxFs = fs[CW-1:0]; rxLf = lf[CW-1:0]; reqLegal = legal;
    tick();
    rxValid = 1'b0; reqLegal = 1'b0;
  endtask

  task automatic pulseStart();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nApplied, nBad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    want("R1", F_EC, 0); want("R1", F_BUSY, 0); want("R1", F_DONE, 0);
    want("R1", F_FAIL, 0); want("R1", F_PRE, 0); want("R1", F_ISP, 0);
    want("R1", F_REJ, 0);

    // R2 start without rate
    roleDown = 1'b1; rateOk = 1'b0;
    pulseStart();
    want("R2", F_BUSY, 0); want("R2", F_EC, 0); want("R2", F_DONE, 0);

    // Downstream role, full flow
    rateOk = 1'b1;
    pulseStart();
    want("R3", F_EC, 1); want("R3", F_BUSY, 1);
    qualLow = 1'b1;
    sendTs(2'b01, 0, 0, 0, 0, 0, 40, 10, 0);
    want("R5", F_FS, 40); want("R6", F_EC, 1);
    sendTs(2'b01, 0, 0, 0, 0, 0, 44, 12, 0);
    want("R6", F_EC, 2); want("R5", F_FS, 44); want("R5", F_LF, 12);
    sendTs(2'b10, 0, 0, 3, 30, 7, 0, 0, 1);
    want("R7", F_PRE, 3); want("R7", F_CUR, 30); want("R7", F_POST, 7);
    want("R7", F_ISP, 0);
    sendTs(2'b10, 1, 5, 0, 0, 0, 0, 0, 1);
    want("R7", F_ISP, 1); want("R7", F_PSET, 5); want("R7", F_PRE, 3);
    sendTs(2'b10, 0, 0, 9, 20, 9, 0, 0, 0);
    want("R8", F_REJ, 1); want("R8", F_PRE, 3); want("R8", F_ISP, 1);
    want("R8", F_EC, 2);
    sendTs(2'b10, 0, 0, 4, 28, 8, 0, 0, 1);
    want("R8", F_REJ, 0); want("R7", F_PRE, 4); want("R7", F_ISP, 0);
    sendTs(2'b11, 0, 0, 0, 0, 0, 0, 0, 0);
    sendTs(2'b00, 0, 0, 0, 0, 0, 0, 0, 0);
    sendTs(2'b11, 0, 0, 0, 0, 0, 0, 0, 0);
    want("R9", F_EC, 2);
    sendTs(2'b11, 0, 0, 0, 0, 0, 0, 0, 0);
    want("R9", F_EC, 3);
    sendTs(2'b11, 0, 0, 1, 1, 1, 0, 0, 1);
    want("R12", F_PRE, 4); want("R12", F_EC, 3);
    qualHigh = 1'b1; tick(); qualHigh = 1'b0;
    want("R10", F_DONE, 1); want("R10", F_EC, 0); want("R10", F_BUSY, 0);
    sendTs(2'b10, 0, 0, 2, 2, 2, 0, 0, 1);
    want("R12", F_PRE, 4);

    // Upstream role, full flow
    roleDown = 1'b0; qualLow = 1'b0;
    pulseStart();
    want("R13", F_DONE, 0); want("R3", F_EC, 0); want("R3", F_BUSY, 1);
    sendTs(2'b01, 0, 0, 0, 0, 0, 0, 0, 0);
    sendTs(2'b01, 0, 0, 0, 0, 0, 0, 0, 0);
    want("R4", F_EC, 0);
    qualLow = 1'b1;
    sendTs(2'b00, 0, 0, 0, 0, 0, 0, 0, 0);
    sendTs(2'b01, 0, 0, 0, 0, 0, 0, 0, 0);
    want("R4", F_EC, 0);
    sendTs(2'b01, 0, 0, 0, 0, 0, 0, 0, 0);
    want("R4", F_EC, 1);
    sendTs(2'b01, 0, 0, 0, 0, 0, 20, 5, 0);
    sendTs(2'b01, 0, 0, 0, 0, 0, 20, 5, 0);
    want("R6", F_EC, 2);
    sendTs(2'b10, 0, 0, 5, 5, 5, 0, 0, 1);
    want("R12", F_PRE, 4); want("R12", F_ISP, 0);
    qualHigh = 1'b1; tick(); qualHigh = 1'b0;
    want("R10", F_EC, 3);
    sendTs(2'b11, 1, 7, 0, 0, 0, 0, 0, 1);
    want("R7", F_ISP, 1); want("R7", F_PSET, 7); want("R7", F_PRE, 4);
    sendTs(2'b00, 0, 0, 0, 0, 0, 0, 0, 0);
    want("R9", F_DONE, 0);
    sendTs(2'b00, 0, 0, 0, 0, 0, 0, 0, 0);
    want("R9", F_DONE, 1); want("R9", F_EC, 0);

    // Early exit out of phase 1
    roleDown = 1'b1;
    pulseStart();
    sendTs(2'b01, 0, 0, 0, 0, 0, 0, 0, 0);
    qualHigh = 1'b1;
    sendTs(2'b01, 0, 0, 0, 0, 0, 0, 0, 0);
    qualHigh = 1'b0;
    want("R6", F_DONE, 1); want("R6", F_EC, 0); want("R6", F_BUSY, 0);

    // Timeout
    toutLimit = 16'd5;
    pulseStart();
    repeat (5) tick();
    want("R11", F_FAIL, 0); want("R11", F_BUSY, 1);
    tick();
    want("R11", F_FAIL, 1); want("R11", F_BUSY, 0); want("R11", F_EC, 0);
    want("R11", F_DONE, 0);

    // Re-arm after failure and mid-phase
    toutLimit = 16'd40;
    roleDown = 1'b0;
    pulseStart();
    want("R13", F_FAIL, 0); want("R13", F_BUSY, 1); want("R13", F_EC, 0);
    roleDown = 1'b1;
    pulseStart();
    want("R13", F_EC, 1);

    @(negedge clk);
    #1;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nApplied, nBad);
    $finish;
  end

endmodule